// File: doc/BRIEF.md
# Lockable Board Control Register Bank

This block is a bank of board-level control and status registers on a simple 32-bit register bus. The bus has an address, a write enable, write data and a combinational read-data return. The bank holds an LED register and two set/clear flag registers, one volatile and one that survives soft reset. It also holds a key register that guards a reset-control register, a display-control register with a read-only field, a card-status register fed from two level inputs, and a free-running timestamp counter. A few fixed-value locations return identification and constant words.

Software unlocks the reset-control register by writing the key value. A write to reset control with the variant's trigger bit set produces a one-cycle reset-request pulse. On the first board variant, each write to the display-control register also sets a 2-bit display-format selector output. One parameter picks the board variant. The two variants differ in the reset trigger bit, in whether the selector is driven, and in where the write-protect bit sits in the card-status word.

Top module: `board_ctl_regs`

## Requirements
- R1: A write to offset 0x20 whose full data equals 0x0000A05F stores 0xA05F and unlocks the bank. Any other write there stores data[15:0] AND 0x7FFF, which leaves the bank locked. A read of 0x20 returns the stored 16-bit value, zero-extended.
- R2: A write to 0x30 ORs the data into the flag register and a write to 0x34 clears the flag bits that are 1 in the data. A read of 0x30 returns the flags.
- R3: The persistent flag register uses the same scheme, setting at 0x38, clearing at 0x3C and reading at 0x38. It keeps its value through soft reset.
- R4: A write to reset control at 0x40 updates the stored level only while the key register holds 0xA05F. A read of 0x40 returns the stored level.
- R5: An accepted write to 0x40 raises reset_req_o for exactly the one cycle after the write edge, if the trigger bit of the data is set. The trigger is bit 8 for VARIANT 0 and bit 2 for VARIANT 1. No pulse occurs while the bank is locked.
- R6: The display-control register at 0x50 resets to 0x00001F00. Bits 13:8 keep their reset value, and all other bits take the written data.
- R7: For VARIANT 0, disp_mux_o takes bits 1:0 of each write to 0x50, starting on the cycle after the write. For VARIANT 1, disp_mux_o stays 0.
- R8: Card status at 0x48 reads card_detect_i in bit 0. It reads write_prot_i in bit 2 for VARIANT 0 and in bit 1 for VARIANT 1, and all other bits read 0. The inputs are registered, so they show on the cycle after they change. Writes to 0x48 have no effect.
- R9: Offset 0x5C returns a free-running counter that advances on average TICK_HZ/CLK_HZ per clock, which is exactly once every two clocks with the defaults.
- R10: Offset 0x00 returns BOARD_ID, 0x44 reads 0x00000001 and 0x88 reads 0xFF000000. The switch location 0x04 and the oscillator locations 0x0C to 0x1C read zero and ignore writes.
- R11: The LED register at 0x08 is fully readable and writable across all 32 bits.
- R12: soft_rst_i clears the LED, key, flag and reset-level registers. The rst_ni reset clears every register, including the persistent flags.
- R13: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| soft_rst_i | input | 1 | Synchronous soft reset of the volatile registers |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_we_i | input | 1 | Write enable, one write per cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| card_detect_i | input | 1 | Card-present level |
| write_prot_i | input | 1 | Card write-protect level |
| disp_mux_o | output | 2 | Display format selector |
| reset_req_o | output | 1 | One-cycle reset-request pulse |

## Verification
The bench builds two copies side by side on one shared bus. One copy uses VARIANT 0 and the other VARIANT 1, each with its own BOARD_ID, and both keep the default 48 MHz clock and 24 MHz tick. Every stimulus therefore shows both trigger bits, both card-status layouts and both behaviours of the selector output in the same cycle. With the default clock ratio the timestamp steps once every two clocks, so an exact count difference can be checked.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

   localparam int unsigned LOCK_W = 16;

   localparam logic [11:0] OFF_ID       = 12'h000;
   localparam logic [11:0] OFF_LED      = 12'h008;
   localparam logic [11:0] OFF_KEY      = 12'h020;
   localparam logic [11:0] OFF_FLAG_SET = 12'h030;
   localparam logic [11:0] OFF_FLAG_CLR = 12'h034;
   localparam logic [11:0] OFF_PERS_SET = 12'h038;
   localparam logic [11:0] OFF_PERS_CLR = 12'h03C;
   localparam logic [11:0] OFF_RSTCTL   = 12'h040;
   localparam logic [11:0] OFF_BUSCFG   = 12'h044;
   localparam logic [11:0] OFF_CARD     = 12'h048;
   localparam logic [11:0] OFF_DISP     = 12'h050;
   localparam logic [11:0] OFF_STAMP    = 12'h05C;
   localparam logic [11:0] OFF_CPUINFO  = 12'h088;

   localparam logic [31:0] UNLOCK_KEY   = 32'h0000_A05F;
   localparam logic [31:0] BUSCFG_VAL   = 32'h0000_0001;
   localparam logic [31:0] CPUINFO_VAL  = 32'hFF00_0000;

endpackage

// File: rtl/bc_key_reset.sv
module bc_key_reset #(
   parameter int unsigned VARIANT = 0,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              soft_rst_i,
   input  logic                              key_we_i,
   input  logic                              rst_we_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic [board_ctl_pkg::LOCK_W-1:0]  key_o,
   output logic [DATA_W-1:0]                 level_o,
   output logic                              reset_req_o
);
   localparam int unsigned KW = board_ctl_pkg::LOCK_W;
   localparam logic [KW-1:0]     KEY_SHORT = KW'(board_ctl_pkg::UNLOCK_KEY);
   localparam logic [DATA_W-1:0] KEY_FULL  = DATA_W'(board_ctl_pkg::UNLOCK_KEY);
   localparam logic [KW-1:0]     KEEP_MASK = {1'b0, {(KW-1){1'b1}}};

   if (VARIANT > 1) begin : g_bad_variant
      $error("bc_key_reset: VARIANT must be 0 or 1");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("bc_key_reset: DATA_W too small");
   end

   logic [KW-1:0]     key_q;
   logic [DATA_W-1:0] level_q;
   logic              req_q;
   logic              unlocked;
   logic              trig;

   assign unlocked = (key_q == KEY_SHORT);

   if (VARIANT == 0) begin : g_trig_a
      assign trig = wdata_i[8];
   end else begin : g_trig_b
      assign trig = wdata_i[2];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q   <= '0;
         level_q <= '0;
         req_q   <= 1'b0;
      end else if (soft_rst_i) begin
         key_q   <= '0;
         level_q <= '0;
         req_q   <= 1'b0;
      end else begin
         if (key_we_i) begin
            key_q <= (wdata_i == KEY_FULL) ? KEY_SHORT : (wdata_i[KW-1:0] & KEEP_MASK);
         end
         if (rst_we_i && unlocked) begin
            level_q <= wdata_i;
         end
         req_q <= rst_we_i && unlocked && trig;
      end
   end

   assign key_o       = key_q;
   assign level_o     = level_q;
   assign reset_req_o = req_q;

   a_r5_req_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |-> $past(rst_we_i && unlocked && trig && !soft_rst_i));

   a_r1_plain_write_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (key_we_i && !soft_rst_i && wdata_i != KEY_FULL) |=> !key_o[KW-1]);

   a_r4_level_held_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!unlocked && !soft_rst_i) |=> $stable(level_o));

endmodule

// File: rtl/bc_flag_reg.sv
module bc_flag_reg #(
   parameter int unsigned DATA_W       = 32,
   parameter bit          KEEP_ON_SOFT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              soft_rst_i,
   input  logic              set_we_i,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] flags_o
);
   if (DATA_W == 0) begin : g_bad_width
      $error("bc_flag_reg: DATA_W must be nonzero");
   end

   logic [DATA_W-1:0] flags_q;
   logic [DATA_W-1:0] set_mask;
   logic [DATA_W-1:0] clr_mask;
   logic [DATA_W-1:0] flags_nxt;

   assign set_mask  = set_we_i ? wdata_i : '0;
   assign clr_mask  = clr_we_i ? wdata_i : '0;
   assign flags_nxt = (flags_q | set_mask) & ~clr_mask;

   if (KEEP_ON_SOFT) begin : g_persistent
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) flags_q <= '0;
         else         flags_q <= flags_nxt;
      end

      a_r3_kept_on_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (soft_rst_i && !set_we_i && !clr_we_i) |=> $stable(flags_o));
   end else begin : g_volatile
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)         flags_q <= '0;
         else if (soft_rst_i) flags_q <= '0;
         else                 flags_q <= flags_nxt;
      end

      a_r12_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
         soft_rst_i |=> (flags_o == '0));
   end

   assign flags_o = flags_q;

   a_r2_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i |=> ((flags_o & $past(wdata_i)) == '0));

endmodule

// File: rtl/bc_disp_card.sv
module bc_disp_card #(
   parameter int unsigned       VARIANT   = 0,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       RO_LSB    = 8,
   parameter int unsigned       RO_MSB    = 13,
   parameter logic [DATA_W-1:0] RESET_VAL = 'h1F00
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              disp_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              card_det_i,
   input  logic              wr_prot_i,
   output logic [DATA_W-1:0] disp_o,
   output logic [1:0]        mux_o,
   output logic [DATA_W-1:0] card_o
);
   localparam int unsigned RO_W = RO_MSB - RO_LSB + 1;
   localparam logic [DATA_W-1:0] RO_MASK =
      DATA_W'(((64'd1 << RO_W) - 64'd1) << RO_LSB);

   if (VARIANT > 1) begin : g_bad_variant
      $error("bc_disp_card: VARIANT must be 0 or 1");
   end
   if (RO_MSB < RO_LSB || RO_MSB >= DATA_W || RO_LSB < 2) begin : g_bad_field
      $error("bc_disp_card: read-only field out of range");
   end

   logic [DATA_W-1:0] disp_q;
   logic [2:0]        card_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        disp_q <= RESET_VAL;
      else if (disp_we_i) disp_q <= (disp_q & RO_MASK) | (wdata_i & ~RO_MASK);
   end

   if (VARIANT == 0) begin : g_mux_a
      logic [1:0] mux_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        mux_q <= 2'b00;
         else if (disp_we_i) mux_q <= wdata_i[1:0];
      end
      assign mux_o = mux_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) card_q <= 3'b000;
         else         card_q <= {wr_prot_i, 1'b0, card_det_i};
      end

      a_r7_mux_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
         disp_we_i |=> (mux_o == $past(wdata_i[1:0])));
   end else begin : g_mux_b
      assign mux_o = 2'b00;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) card_q <= 3'b000;
         else         card_q <= {1'b0, wr_prot_i, card_det_i};
      end
   end

   assign disp_o = disp_q;
   assign card_o = DATA_W'(card_q);

   a_r6_ro_field_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_we_i |=> ((disp_o & RO_MASK) == ($past(disp_o) & RO_MASK)));

   a_r8_card_detect_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (card_o[0] == $past(card_det_i)));

endmodule

// File: rtl/bc_timestamp.sv
module bc_timestamp #(
   parameter int unsigned CLK_HZ  = 48_000_000,
   parameter int unsigned TICK_HZ = 24_000_000,
   parameter int unsigned STAMP_W = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   output logic [STAMP_W-1:0] stamp_o
);
   localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;
   localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
   localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

   if (TICK_HZ == 0 || TICK_HZ > CLK_HZ) begin : g_bad_rate
      $error("bc_timestamp: TICK_HZ must be in 1..CLK_HZ");
   end
   if (STAMP_W == 0) begin : g_bad_width
      $error("bc_timestamp: STAMP_W must be nonzero");
   end

   logic [ACC_W-1:0]   acc_q;
   logic [ACC_W-1:0]   acc_sum;
   logic [STAMP_W-1:0] stamp_q;
   logic               carry;

   assign acc_sum = acc_q + STEP;
   assign carry   = (acc_sum >= WRAP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= '0;
         stamp_q <= '0;
      end else begin
         acc_q   <= carry ? (acc_sum - WRAP) : acc_sum;
         stamp_q <= stamp_q + STAMP_W'(carry);
      end
   end

   assign stamp_o = stamp_q;

   a_r9_stamp_steps_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (stamp_o == $past(stamp_o) || stamp_o == $past(stamp_o) + 1'b1));

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
   parameter int unsigned       VARIANT  = 0,
   parameter int unsigned       ADDR_W   = 12,
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] BOARD_ID = '0,
   parameter int unsigned       CLK_HZ   = 48_000_000,
   parameter int unsigned       TICK_HZ  = 24_000_000,
   parameter int unsigned       STAMP_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              soft_rst_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              card_detect_i,
   input  logic              write_prot_i,
   output logic [1:0]        disp_mux_o,
   output logic              reset_req_o
);
   import board_ctl_pkg::*;

   if (DATA_W != 32) begin : g_bad_data
      $error("board_ctl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("board_ctl_regs: ADDR_W must be 8..32");
   end
   if (STAMP_W > DATA_W) begin : g_bad_stamp
      $error("board_ctl_regs: STAMP_W exceeds DATA_W");
   end

   localparam logic [ADDR_W-1:0] A_ID       = ADDR_W'(OFF_ID);
   localparam logic [ADDR_W-1:0] A_LED      = ADDR_W'(OFF_LED);
   localparam logic [ADDR_W-1:0] A_KEY      = ADDR_W'(OFF_KEY);
   localparam logic [ADDR_W-1:0] A_FLAG_SET = ADDR_W'(OFF_FLAG_SET);
   localparam logic [ADDR_W-1:0] A_FLAG_CLR = ADDR_W'(OFF_FLAG_CLR);
   localparam logic [ADDR_W-1:0] A_PERS_SET = ADDR_W'(OFF_PERS_SET);
   localparam logic [ADDR_W-1:0] A_PERS_CLR = ADDR_W'(OFF_PERS_CLR);
   localparam logic [ADDR_W-1:0] A_RSTCTL   = ADDR_W'(OFF_RSTCTL);
   localparam logic [ADDR_W-1:0] A_BUSCFG   = ADDR_W'(OFF_BUSCFG);
   localparam logic [ADDR_W-1:0] A_CARD     = ADDR_W'(OFF_CARD);
   localparam logic [ADDR_W-1:0] A_DISP     = ADDR_W'(OFF_DISP);
   localparam logic [ADDR_W-1:0] A_STAMP    = ADDR_W'(OFF_STAMP);
   localparam logic [ADDR_W-1:0] A_CPUINFO  = ADDR_W'(OFF_CPUINFO);

   logic [DATA_W-1:0]  led_q;
   logic [LOCK_W-1:0]  key_val;
   logic [DATA_W-1:0]  level_val;
   logic [DATA_W-1:0]  flag_val;
   logic [DATA_W-1:0]  pers_val;
   logic [DATA_W-1:0]  disp_val;
   logic [DATA_W-1:0]  card_val;
   logic [STAMP_W-1:0] stamp_val;

   logic we_led, we_key, we_fset, we_fclr, we_pset, we_pclr, we_rst, we_disp;

   assign we_led  = bus_we_i && (bus_addr_i == A_LED);
   assign we_key  = bus_we_i && (bus_addr_i == A_KEY);
   assign we_fset = bus_we_i && (bus_addr_i == A_FLAG_SET);
   assign we_fclr = bus_we_i && (bus_addr_i == A_FLAG_CLR);
   assign we_pset = bus_we_i && (bus_addr_i == A_PERS_SET);
   assign we_pclr = bus_we_i && (bus_addr_i == A_PERS_CLR);
   assign we_rst  = bus_we_i && (bus_addr_i == A_RSTCTL);
   assign we_disp = bus_we_i && (bus_addr_i == A_DISP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         led_q <= '0;
      else if (soft_rst_i) led_q <= '0;
      else if (we_led)     led_q <= bus_wdata_i;
   end

   bc_key_reset #(
      .VARIANT (VARIANT),
      .DATA_W  (DATA_W)
   ) i_key_reset (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .soft_rst_i  (soft_rst_i),
      .key_we_i    (we_key),
      .rst_we_i    (we_rst),
      .wdata_i     (bus_wdata_i),
      .key_o       (key_val),
      .level_o     (level_val),
      .reset_req_o (reset_req_o)
   );

   bc_flag_reg #(
      .DATA_W       (DATA_W),
      .KEEP_ON_SOFT (1'b0)
   ) i_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .set_we_i   (we_fset),
      .clr_we_i   (we_fclr),
      .wdata_i    (bus_wdata_i),
      .flags_o    (flag_val)
   );

   bc_flag_reg #(
      .DATA_W       (DATA_W),
      .KEEP_ON_SOFT (1'b1)
   ) i_pers_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .set_we_i   (we_pset),
      .clr_we_i   (we_pclr),
      .wdata_i    (bus_wdata_i),
      .flags_o    (pers_val)
   );

   bc_disp_card #(
      .VARIANT   (VARIANT),
      .DATA_W    (DATA_W),
      .RO_LSB    (8),
      .RO_MSB    (13),
      .RESET_VAL (DATA_W'(32'h0000_1F00))
   ) i_disp_card (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .disp_we_i  (we_disp),
      .wdata_i    (bus_wdata_i),
      .card_det_i (card_detect_i),
      .wr_prot_i  (write_prot_i),
      .disp_o     (disp_val),
      .mux_o      (disp_mux_o),
      .card_o     (card_val)
   );

   bc_timestamp #(
      .CLK_HZ  (CLK_HZ),
      .TICK_HZ (TICK_HZ),
      .STAMP_W (STAMP_W)
   ) i_stamp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stamp_o (stamp_val)
   );

   always_comb begin
      case (bus_addr_i)
         A_ID:       bus_rdata_o = BOARD_ID;
         A_LED:      bus_rdata_o = led_q;
         A_KEY:      bus_rdata_o = DATA_W'(key_val);
         A_FLAG_SET: bus_rdata_o = flag_val;
         A_PERS_SET: bus_rdata_o = pers_val;
         A_RSTCTL:   bus_rdata_o = level_val;
         A_BUSCFG:   bus_rdata_o = DATA_W'(BUSCFG_VAL);
         A_CARD:     bus_rdata_o = card_val;
         A_DISP:     bus_rdata_o = disp_val;
         A_STAMP:    bus_rdata_o = DATA_W'(stamp_val);
         A_CPUINFO:  bus_rdata_o = DATA_W'(CPUINFO_VAL);
         default:    bus_rdata_o = '0;
      endcase
   end

   a_r11_led_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_led && !soft_rst_i) |=> (led_q == $past(bus_wdata_i)));

endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;
   localparam int CLK_PERIOD = 10;
   localparam int P_RDATA = 0;
   localparam int P_REQ   = 1;
   localparam int P_MUX   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic        cd = 1'b0;
   logic        wp = 1'b0;
   logic        chk_valid = 1'b0;

   logic [31:0] rdata_a, rdata_b;
   logic [1:0]  mux_a, mux_b;
   logic        req_a, req_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int          q_probe[$];
   logic [31:0] q_ea[$];
   logic [31:0] q_eb[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   board_ctl_regs #(.VARIANT(0), .BOARD_ID(32'h0126_0000)) i_board_ctl_regs (
      .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
      .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a),
      .card_detect_i(cd), .write_prot_i(wp), .disp_mux_o(mux_a), .reset_req_o(req_a));

   board_ctl_regs #(.VARIANT(1), .BOARD_ID(32'h0178_0000)) i_board_ctl_regs_b (
      .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
      .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b),
      .card_detect_i(cd), .write_prot_i(wp), .disp_mux_o(mux_b), .reset_req_o(req_b));

   // scoreboard monitor: pops one expectation per flagged cycle
   always @(negedge clk) begin
      int          p;
      logic [31:0] ea, eb, aa, ab;
      string       tg;
      if (chk_valid && q_probe.size() > 0) begin
         p  = q_probe.pop_front();
         ea = q_ea.pop_front();
         eb = q_eb.pop_front();
         tg = q_tag.pop_front();
         case (p)
            P_REQ:   begin aa = {31'b0, req_a}; ab = {31'b0, req_b}; end
            P_MUX:   begin aa = {30'b0, mux_a}; ab = {30'b0, mux_b}; end
            default: begin aa = rdata_a; ab = rdata_b; end
         endcase
         n_checks++;
         if (aa !== ea || ab !== eb) begin
            n_fail++;
            $display("FAIL %s probe %0d: actual A=%h B=%h expected A=%h B=%h",
                     tg, p, aa, ab, ea, eb);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic expect_p(input int p, input logic [31:0] ea, input logic [31:0] eb,
                           input string tag);
      q_probe.push_back(p); q_ea.push_back(ea); q_eb.push_back(eb); q_tag.push_back(tag);
      chk_valid = 1'b1;
      @(posedge clk); #1;
      chk_valid = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] ea, input logic [31:0] eb,
                     input string tag);
      addr = a;
      expect_p(P_RDATA, ea, eb, tag);
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] t1a, t1b, t2a, t2b;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();

      // reset state and fixed locations
      rd(12'h050, 32'h0000_1F00, 32'h0000_1F00, "R6 display reset value");
      rd(12'h020, 32'h0, 32'h0, "R1 key reset");
      rd(12'h000, 32'h0126_0000, 32'h0178_0000, "R10 board id");
      rd(12'h044, 32'h1, 32'h1, "R10 bus cfg constant");
      rd(12'h088, 32'hFF00_0000, 32'hFF00_0000, "R10 cpu info constant");
      expect_p(P_MUX, 32'h0, 32'h0, "R7 mux reset");
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h014, 32'h1234_5678);
      rd(12'h004, 32'h0, 32'h0, "R10 switch reads zero");
      rd(12'h014, 32'h0, 32'h0, "R10 oscillator reads zero");

      // LED
      wr(12'h008, 32'hDEAD_BEEF);
      rd(12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R11 led readback");

      // flags
      wr(12'h030, 32'h0000_0F0F);
      wr(12'h030, 32'h3000_0000);
      rd(12'h030, 32'h3000_0F0F, 32'h3000_0F0F, "R2 flags set accumulate");
      wr(12'h034, 32'h0000_0F00);
      rd(12'h030, 32'h3000_000F, 32'h3000_000F, "R2 flags clear");

      // persistent flags
      wr(12'h038, 32'h0000_00A5);
      wr(12'h03C, 32'h0000_0005);
      rd(12'h038, 32'h0000_00A0, 32'h0000_00A0, "R3 persistent set clear");

      // reset control while locked
      wr(12'h040, 32'h0000_0104);
      expect_p(P_REQ, 32'h0, 32'h0, "R5 no pulse when locked");
      rd(12'h040, 32'h0, 32'h0, "R4 level ignored when locked");
      wr(12'h020, 32'h0000_FFFF);
      rd(12'h020, 32'h0000_7FFF, 32'h0000_7FFF, "R1 non-key masked");
      wr(12'h040, 32'h0000_0104);
      expect_p(P_REQ, 32'h0, 32'h0, "R5 no pulse with wrong key");

      // unlock and trigger
      wr(12'h020, 32'h0000_A05F);
      rd(12'h020, 32'h0000_A05F, 32'h0000_A05F, "R1 key stored");
      wr(12'h040, 32'h0000_0100);
      expect_p(P_REQ, 32'h1, 32'h0, "R5 bit8 trigger");
      expect_p(P_REQ, 32'h0, 32'h0, "R5 pulse one cycle");
      rd(12'h040, 32'h0000_0100, 32'h0000_0100, "R4 level stored");
      wr(12'h040, 32'h0000_0004);
      expect_p(P_REQ, 32'h0, 32'h1, "R5 bit2 trigger");
      expect_p(P_REQ, 32'h0, 32'h0, "R5 pulse one cycle b");
      rd(12'h040, 32'h0000_0004, 32'h0000_0004, "R4 level updated");

      // key with extra high bit is not the key
      wr(12'h020, 32'h0001_A05F);
      rd(12'h020, 32'h0000_205F, 32'h0000_205F, "R1 near-key relocks");
      wr(12'h040, 32'h0000_0104);
      expect_p(P_REQ, 32'h0, 32'h0, "R5 relocked no pulse");
      rd(12'h040, 32'h0000_0004, 32'h0000_0004, "R4 relocked level kept");

      // display control
      wr(12'h050, 32'hFFFF_FFFE);
      expect_p(P_MUX, 32'h2, 32'h0, "R7 mux from write");
      rd(12'h050, 32'hFFFF_DFFE, 32'hFFFF_DFFE, "R6 read-only field kept");
      wr(12'h050, 32'h0000_3F01);
      expect_p(P_MUX, 32'h1, 32'h0, "R7 mux second write");
      rd(12'h050, 32'h0000_1F01, 32'h0000_1F01, "R6 writable bits cleared");

      // card status
      cd = 1'b1; wp = 1'b0;
      idle();
      rd(12'h048, 32'h1, 32'h1, "R8 card detect bit0");
      cd = 1'b0; wp = 1'b1;
      idle();
      rd(12'h048, 32'h4, 32'h2, "R8 write protect layout");
      wr(12'h048, 32'hFFFF_FFFF);
      rd(12'h048, 32'h4, 32'h2, "R8 write ignored");

      // unmapped
      wr(12'hF00, 32'hFFFF_FFFF);
      rd(12'hF00, 32'h0, 32'h0, "R13 unmapped reads zero");
      rd(12'h034, 32'h0, 32'h0, "R13 clear address reads zero");
      rd(12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R13 unmapped write no effect");

      // soft reset
      wr(12'h020, 32'h0000_A05F);
      soft_rst = 1'b1;
      idle();
      soft_rst = 1'b0;
      rd(12'h008, 32'h0, 32'h0, "R12 soft clears led");
      rd(12'h020, 32'h0, 32'h0, "R12 soft clears key");
      rd(12'h030, 32'h0, 32'h0, "R12 soft clears flags");
      rd(12'h040, 32'h0, 32'h0, "R12 soft clears level");
      rd(12'h038, 32'h0000_00A0, 32'h0000_00A0, "R3 persistent survives soft");
      rd(12'h050, 32'h0000_1F01, 32'h0000_1F01, "R12 display untouched by soft");

      // timestamp rate
      addr = 12'h05C;
      @(negedge clk);
      t1a = rdata_a; t1b = rdata_b;
      repeat (20) @(negedge clk);
      t2a = rdata_a; t2b = rdata_b;
      n_checks++;
      if ((t2a - t1a) !== 32'd10 || (t2b - t1b) !== 32'd10) begin
         n_fail++;
         $display("FAIL R9 stamp delta: actual A=%0d B=%0d expected 10",
                  t2a - t1a, t2b - t1b);
      end
      @(posedge clk); #1;

      // full reset clears persistent flags
      rst_n = 1'b0;
      idle();
      rst_n = 1'b1;
      idle();
      rd(12'h038, 32'h0, 32'h0, "R12 full reset clears persistent");

      idle();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule